// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block rebuilds the four arithmetic condition flags (negative, zero, overflow, carry) and the extend bit from a saved operation class and two saved operand words, instead of producing them inside the adder at the time the arithmetic happens. A pipeline that postpones flag work keeps only the class code, the result word and the source word of the last flag-setting operation. When the flags are finally needed, it hands those three values to this block and receives the packed flag field one clock later.

The same datapath also serves multi-word arithmetic chained through the extend bit. For the add-with-extend and subtract-with-extend classes the new extend bit equals the carry or borrow. The zero flag can only stay set if it was set before the step, so a long operand reads as zero only when every word of it was zero. Compares at byte and word width reuse the subtract rules on the low bits of the operands.

Control is a two-state machine. `ST_IDLE` means no result is on show. `ST_SHOW` means the output register holds a result captured on the previous edge. The transition from either state to `ST_SHOW` is `req_accept` (request valid). The transition from either state to `ST_IDLE` is `req_absent`. Reset enters `ST_IDLE`.

Top module: `ccf_lazy_eval`

## Requirements
- R1: After reset `out_valid` is 0, `out_flags` is 0 and `out_err` is 0.
- R2: A request sampled on one rising edge shows its result on `out_valid`, `out_flags` and `out_err` after that same edge. `out_valid` is high only in cycles that follow a request. When no request is sampled, `out_flags` and `out_err` keep their previous values.
- R3: `out_flags` packs {X, N, Z, V, C} in bits 4 down to 0. Class codes on `req_op` are: 0 pass, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-with-extend, 7 subtract-with-extend, 8 shift. The pass class copies `req_result[3:0]` to N, Z, V, C (bit 3 to N, bit 2 to Z, bit 1 to V, bit 0 to C) and keeps X equal to `req_xin`.
- R4: Logic class: Z is set if the result word is zero, otherwise N equals the result's sign bit. V and C are 0 and X is kept.
- R5: Add class: the first operand is taken as result minus source. C is set when the result is below the source (unsigned). V is set on signed overflow of first operand plus source. X equals C.
- R6: Subtract class: the first operand is taken as result plus source. C is set when the first operand is below the source (unsigned). V is set on signed overflow of first operand minus source. X equals C.
- R7: Byte compare and word compare apply the rules of R6 to bits 7:0 and bits 15:0 of the operands. N and Z come from those low bits. X is kept.
- R8: Add-with-extend: the first operand is result minus source minus 1. C is set when the result is less than or equal to the source. V is set on signed overflow of the three-input sum. X equals C.
- R9: Subtract-with-extend: the first operand is result plus source plus 1. C is set when the first operand is less than or equal to the source. V is set on signed overflow of first operand minus source minus 1. X equals C.
- R10: For add-with-extend and subtract-with-extend, the output Z is the computed Z ANDed with `req_prev_z`. A clear prior Z keeps Z clear.
- R11: Shift class: C and X are both set exactly when the source word is nonzero. V is 0, and N and Z follow the result word as in R4.
- R12: Class codes 9 to 15 give `out_flags` equal to 0 (including X) and `out_err` = 1. Every defined class gives `out_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Saved operation class code |
| req_result | input | 32 | Saved result word |
| req_source | input | 32 | Saved source word |
| req_xin | input | 1 | Current extend bit |
| req_prev_z | input | 1 | Z bit of the flags held before this operation |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_flags | output | 5 | {X, N, Z, V, C} |
| out_err | output | 1 | Undefined class code was requested |

## Verification
Two functions can land in the same cycle. One is the output register reloading with a new request. The other is that register presenting the previous request's result. The bench provokes this with long back-to-back request bursts, alternated with idle gaps, across all sixteen class codes. A scoreboard queue pairs each shown result with the request that produced it, one cycle earlier. The bench judges idle cycles separately: it checks that the shown flags do not move while no request arrives.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [3:0] {
        OPC_PASS  = 4'd0,
        OPC_LOGIC = 4'd1,
        OPC_ADD   = 4'd2,
        OPC_SUB   = 4'd3,
        OPC_CMP8  = 4'd4,
        OPC_CMP16 = 4'd5,
        OPC_ADDX  = 4'd6,
        OPC_SUBX  = 4'd7,
        OPC_SHIFT = 4'd8
    } ccf_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ccf_state_e;

    localparam int FLAG_W = $bits(ccf_flags_t);

endpackage

// File: rtl/ccf_nz_detect.sv
module ccf_nz_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic         n,
    output logic         z
);
    always_comb begin
        z = (val == '0);
        n = !z && val[W-1];
    end
endmodule

// File: rtl/ccf_carry_ovf.sv
module ccf_carry_ovf #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic [W-1:0] src,
    input  logic         is_sub,
    input  logic         ext,
    output logic         c,
    output logic         v
);
    logic [W-1:0] ext_w;
    logic [W-1:0] op1;

    assign ext_w = {{(W-1){1'b0}}, ext};

    always_comb begin
        if (is_sub) begin
            // first operand restored from result + source (+1 with extend)
            op1 = res + src + ext_w;
            c   = ext ? (op1 <= src) : (op1 < src);
            v   = (op1[W-1] ^ res[W-1]) & (op1[W-1] ^ src[W-1]);
        end else begin
            // first operand restored from result - source (-1 with extend)
            op1 = res - src - ext_w;
            c   = ext ? (res <= src) : (res < src);
            v   = (src[W-1] ^ res[W-1]) & ~(op1[W-1] ^ src[W-1]);
        end
    end
endmodule

// File: rtl/ccf_flag_core.sv
module ccf_flag_core
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] src,
    input  logic              xin,
    input  logic              prev_z,
    output ccf_flags_t        flags,
    output logic              err
);
    localparam int LANES = 3;   // lane 0 full, lane 1 half, lane 2 quarter width

    logic [LANES-1:0] lane_n;
    logic [LANES-1:0] lane_z;
    logic [LANES-1:0] lane_c;
    logic [LANES-1:0] lane_v;
    logic             full_sub;
    logic             full_ext;
    logic             src_nz;

    assign full_sub = (op == OPC_SUB)  || (op == OPC_SUBX);
    assign full_ext = (op == OPC_ADDX) || (op == OPC_SUBX);
    assign src_nz   = |src;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int LW = DATA_W >> gi;
        logic l_sub;
        logic l_ext;
        if (gi == 0) begin : g_full
            assign l_sub = full_sub;
            assign l_ext = full_ext;
        end else begin : g_cmp
            assign l_sub = 1'b1;
            assign l_ext = 1'b0;
        end
        ccf_nz_detect #(.W(LW)) u_nz (
            .val (res[LW-1:0]),
            .n   (lane_n[gi]),
            .z   (lane_z[gi])
        );
        ccf_carry_ovf #(.W(LW)) u_cv (
            .res    (res[LW-1:0]),
            .src    (src[LW-1:0]),
            .is_sub (l_sub),
            .ext    (l_ext),
            .c      (lane_c[gi]),
            .v      (lane_v[gi])
        );
    end

    always_comb begin
        flags = '0;
        err   = 1'b0;
        unique case (op)
            OPC_PASS: begin
                flags.x = xin;
                flags.n = res[3];
                flags.z = res[2];
                flags.v = res[1];
                flags.c = res[0];
            end
            OPC_LOGIC: begin
                flags.x = xin;
                flags.n = lane_n[0];
                flags.z = lane_z[0];
            end
            OPC_ADD, OPC_SUB: begin
                flags.n = lane_n[0];
                flags.z = lane_z[0];
                flags.v = lane_v[0];
                flags.c = lane_c[0];
                flags.x = lane_c[0];
            end
            OPC_ADDX, OPC_SUBX: begin
                flags.n = lane_n[0];
                flags.z = lane_z[0] & prev_z;   // a clear Z stays clear
                flags.v = lane_v[0];
                flags.c = lane_c[0];
                flags.x = lane_c[0];
            end
            OPC_CMP16: begin
                flags.x = xin;
                flags.n = lane_n[1];
                flags.z = lane_z[1];
                flags.v = lane_v[1];
                flags.c = lane_c[1];
            end
            OPC_CMP8: begin
                flags.x = xin;
                flags.n = lane_n[2];
                flags.z = lane_z[2];
                flags.v = lane_v[2];
                flags.c = lane_c[2];
            end
            OPC_SHIFT: begin
                flags.n = lane_n[0];
                flags.z = lane_z[0];
                flags.c = src_nz;
                flags.x = src_nz;
            end
            default: begin
                flags = '0;
                err   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ccf_lazy_eval.sv
module ccf_lazy_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [DATA_W-1:0] req_result,
    input  logic [DATA_W-1:0] req_source,
    input  logic              req_xin,
    input  logic              req_prev_z,
    output logic              out_valid,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_err
);
    ccf_state_e state_q;
    ccf_state_e state_d;
    ccf_flags_t core_flags;
    logic       core_err;
    ccf_flags_t flags_q;
    logic       err_q;
    logic [3:0] op_q;

    ccf_flag_core #(.DATA_W(DATA_W)) u_core (
        .op     (req_op),
        .res    (req_result),
        .src    (req_source),
        .xin    (req_xin),
        .prev_z (req_prev_z),
        .flags  (core_flags),
        .err    (core_err)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            err_q   <= 1'b0;
            op_q    <= 4'd0;
        end else if (req_valid) begin
            flags_q <= core_flags;
            err_q   <= core_err;
            op_q    <= req_op;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_SHOW);
        out_flags = flags_q;
        out_err   = err_q;
    end

    p_show_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_flags) && $stable(out_err)));

    p_undef_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_flags == '0));

    p_logic_vc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OPC_LOGIC) |-> (out_flags[1:0] == 2'b00));

    p_nz_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q != OPC_PASS) |-> !(out_flags[3] && out_flags[2]));

    p_sticky_z_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OPC_ADDX || req_op == OPC_SUBX) && !req_prev_z)
        |=> !out_flags[2]);

    p_shift_x_eq_c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OPC_SHIFT) |=> (out_flags[4] == out_flags[0]));

endmodule

// File: tb/ccf_lazy_eval_test.sv
module ccf_lazy_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] req_result = '0;
    logic [31:0] req_source = '0;
    logic        req_xin = 1'b0;
    logic        req_prev_z = 1'b0;
    logic        out_valid;
    logic [4:0]  out_flags;
    logic        out_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic [5:0] last_seen = '0;

    always #2.5 clk = ~clk;

    ccf_lazy_eval uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_result(req_result), .req_source(req_source), .req_xin(req_xin),
        .req_prev_z(req_prev_z), .out_valid(out_valid), .out_flags(out_flags),
        .out_err(out_err)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4, 4'd5: return "R7";
            4'd6: return "R8 R10";
            4'd7: return "R9 R10";
            4'd8: return "R11";
            default: return "R12";
        endcase
    endfunction

    // expected {err, X, N, Z, V, C} from the requirement text
    function automatic logic [5:0] model(input logic [3:0] op, input logic [31:0] r,
                                         input logic [31:0] s, input logic x, input logic pz);
        logic n, z, v, c, xo;
        logic [32:0] w;
        logic [31:0] a;
        logic [16:0] w16;
        logic [15:0] a16;
        logic [8:0]  w8;
        logic [7:0]  a8;
        n = (r != 0) && r[31];
        z = (r == 0);
        v = 0; c = 0; xo = x;
        case (op)
            4'd0: return {1'b0, x, r[3:0]};
            4'd1: ;
            4'd2, 4'd6: begin
                a = r - s - ((op == 4'd6) ? 32'd1 : 32'd0);
                w = {1'b0, a} + {1'b0, s} + ((op == 4'd6) ? 33'd1 : 33'd0);
                c = w[32];
                v = (a[31] == s[31]) && (r[31] != s[31]);
                xo = c;
                if (op == 4'd6) z = z & pz;
            end
            4'd3, 4'd7: begin
                a = r + s + ((op == 4'd7) ? 32'd1 : 32'd0);
                w = {1'b0, a} - {1'b0, s} - ((op == 4'd7) ? 33'd1 : 33'd0);
                c = w[32];
                v = (a[31] != s[31]) && (r[31] != a[31]);
                xo = c;
                if (op == 4'd7) z = z & pz;
            end
            4'd5: begin
                a16 = r[15:0] + s[15:0];
                w16 = {1'b0, a16} - {1'b0, s[15:0]};
                c = w16[16];
                v = (a16[15] != s[15]) && (r[15] != a16[15]);
                z = (r[15:0] == 0);
                n = !z && r[15];
            end
            4'd4: begin
                a8 = r[7:0] + s[7:0];
                w8 = {1'b0, a8} - {1'b0, s[7:0]};
                c = w8[8];
                v = (a8[7] != s[7]) && (r[7] != a8[7]);
                z = (r[7:0] == 0);
                n = !z && r[7];
            end
            4'd8: begin
                c = (s != 0);
                xo = c;
            end
            default: return 6'b100000;
        endcase
        return {1'b0, xo, n, z, v, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [5:0] act,
                         input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [31:0] r, input logic [31:0] s,
                        input logic x, input logic pz);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_result = r;
        req_source = s;
        req_xin    = x;
        req_prev_z = pz;
        exp_q.push_back(model(op, r, s, x, pz));
        tag_q.push_back(tag_of(op));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: pops expected items as results appear; checks holding when idle
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", {out_err, out_flags}, 6'bxxxxxx);
                end else begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_err, out_flags} === e, t, {out_err, out_flags}, e);
                end
            end else begin
                check({out_err, out_flags} === last_seen, "R2",
                      {out_err, out_flags}, last_seen);
            end
            last_seen = {out_err, out_flags};
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_flags === 5'd0 && out_err === 1'b0, "R1",
              {out_err, out_flags}, 6'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_flags === 5'd0 && out_err === 1'b0, "R1",
              {out_err, out_flags}, 6'd0);
        mon_on = 1'b1;

        send(4'd0, 32'h0000_001A, 32'h0, 1'b1, 1'b0);  // R3 pass -> 1_1010
        send(4'd1, 32'h0, 32'h5, 1'b0, 1'b0);          // R4 zero
        send(4'd1, 32'h8000_0000, 32'h0, 1'b1, 1'b0);  // R4 negative
        idle(2);
        send(4'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b0);  // R5 overflow
        send(4'd2, 32'h0, 32'h1, 1'b0, 1'b0);          // R5 carry, zero
        send(4'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);  // R6 borrow
        send(4'd3, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0);  // R6 overflow
        send(4'd4, 32'hABCD_0080, 32'h1234_5601, 1'b1, 1'b0); // R7 byte
        send(4'd5, 32'h1234_0000, 32'h0000_8000, 1'b0, 1'b0); // R7 word zero
        send(4'd6, 32'h0, 32'h0, 1'b0, 1'b0);          // R8 R10 res==src, Z cleared
        send(4'd6, 32'h0, 32'h5, 1'b0, 1'b1);          // R8 R10 Z kept
        send(4'd7, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b1);  // R9 src max
        send(4'd7, 32'h0, 32'h3, 1'b1, 1'b0);          // R9 R10
        idle(1);
        send(4'd8, 32'h0, 32'h0, 1'b1, 1'b0);          // R11 no carry
        send(4'd8, 32'h8000_0000, 32'h4, 1'b0, 1'b0);  // R11 carry
        send(4'd9, 32'h1234, 32'h5678, 1'b1, 1'b1);    // R12
        send(4'd15, 32'h0, 32'h0, 1'b1, 1'b1);         // R12
        send(4'd1, 32'h1, 32'h0, 1'b0, 1'b0);          // R12 err clears
        idle(3);

        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r, s;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = (i % 7 == 0) ? r : lfsr;
            if (i % 11 == 0) r = 32'h0;
            send(4'(i % 16), r, s, lfsr[3], lfsr[9]);
            if (i % 13 == 0) idle(2);
        end
        idle(3);
        check(exp_q.size() == 0, "R2", 6'(exp_q.size()), 6'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule